// File: doc/BRIEF.md
# Strobe-Driven FIFO With Half-Full Flag

This block is a first-in first-out buffer of 4096 words of 9 bits, with a separate active-low write strobe and read strobe. All logic runs on a single system clock. Each strobe passes through a two-flop synchronizer and an edge detector. A phase state machine per strobe then decides whether the current strobe cycle is accepted or blocked. The decision is made on the strobe's falling edge. The work completes on its rising edge.

A write cycle that begins while the buffer is not full stores the input word at the write pointer when the strobe rises. A read cycle that begins while the buffer is not empty drives the word at the read pointer onto the output when the strobe falls, and advances the read pointer when it rises. There are three active-low flags: full, empty and half-full. Each flag changes on a specific strobe edge, so the surrounding logic can pace its strobes on them. An active-low asynchronous reset returns both pointers to the first location and sets all three flags to their idle values.

Each strobe phase machine has three named states:
- `PH_IDLE` is the rest state.
- `PH_ACTIVE` is an accepted cycle.
- `PH_BLOCKED` is a refused cycle.

The machine takes these transitions:
- From `PH_IDLE` to `PH_ACTIVE` on a falling edge while not blocked.
- From `PH_IDLE` to `PH_BLOCKED` on a falling edge while blocked.
- From `PH_ACTIVE` back to `PH_IDLE` on a rising edge, which completes the cycle.
- From `PH_BLOCKED` back to `PH_IDLE` on a rising edge, with no effect.

Top module: `strobe_fifo`

## Requirements
- R1: While reset is low, both pointers return to address 0 and the occupancy returns to 0. On the first clock after release, `empty_n`=0, `full_n`=1, `half_n`=1 and `dout`=0.
- R2: A write strobe whose falling edge is seen while `full_n`=1 is accepted. On its rising edge, `din` is stored at the write pointer, the write pointer advances by one and the occupancy grows by one.
- R3: A write strobe whose falling edge is seen while `full_n`=0 is ignored for its whole cycle: nothing is stored, the occupancy is unchanged and `full_n` stays 0.
- R4: A read strobe whose falling edge is seen while `empty_n`=1 drives the word at the read pointer onto `dout` at that falling edge. Its rising edge advances the read pointer and lowers the occupancy by one, so words leave in the order they were written.
- R5: A read strobe whose falling edge is seen while `empty_n`=0 is ignored: `dout` holds its value and the pointers are unchanged.
- R6: `full_n` goes to 0 when a completed write brings the occupancy to the capacity. It returns to 1 only when a read completes.
- R7: `empty_n` is 0 exactly when the occupancy is 0.
- R8: `half_n` goes to 0 at the falling edge of an accepted write when the occupancy at that moment is at least half the capacity.
- R9: `half_n` returns to 1 at the rising edge of a read that leaves the occupancy at or below half the capacity. It never rises at any other time.
- R10: Writes store to sequential addresses even while a read strobe is low, and the addresses wrap modulo the depth.
- R11: A strobe edge takes effect on the third clock edge after the strobe pin changes: two clocks in the synchronizer and one in the phase machine or flag registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| din | input | DW (9) | Word to store |
| dout | output | DW (9) | Word presented by the last accepted read |
| full_n | output | 1 | Full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| half_n | output | 1 | Half-full flag, active low |

## Verification
The assertions take four things for granted about the inputs:
- Each strobe holds each level for at least three clocks, so that every edge is seen exactly once.
- Write and read completions never coincide in a way that would let the occupancy leave its range.
- `din` stays stable from before the write falling edge until the rising edge has been acted on.
- Both strobes are high when reset is released.

The bench keeps within these assumptions. It drives every strobe level for four clocks, holds `din` for the whole write task, and raises reset only with both strobes high. It overlaps a read and a write only by nesting a complete write inside a read strobe that is held low.

// File: rtl/strobe_fifo_pkg.sv
`timescale 1ns/1ps
package strobe_fifo_pkg;
    // Phase of one strobe cycle, as seen by the system clock.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACTIVE  = 2'd1,
        PH_BLOCKED = 2'd2
    } phase_e;
endpackage

// File: rtl/strobe_edge.sv
`timescale 1ns/1ps
module strobe_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall,
    output logic rise
);
    localparam int LAST = SYNC_STAGES;

    // sh[0..SYNC_STAGES-1] synchronize the pin; sh[LAST] holds the previous synchronized level.
    logic [LAST:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[LAST-1:0], strobe_n};
    end

    always_comb begin
        fall = sh[LAST] & ~sh[LAST-1];
        rise = ~sh[LAST] & sh[LAST-1];
    end
endmodule

// File: rtl/strobe_phase_fsm.sv
`timescale 1ns/1ps
module strobe_phase_fsm
    import strobe_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic rise,
    input  logic block,
    output logic start,
    output logic done
);
    phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:    if (fall) state_d = block ? PH_BLOCKED : PH_ACTIVE;
            PH_ACTIVE:  if (rise) state_d = PH_IDLE;
            PH_BLOCKED: if (rise) state_d = PH_IDLE;
            default:    state_d = PH_IDLE;
        endcase
    end

    always_comb begin
        start = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            PH_IDLE:    start = fall & ~block;
            PH_ACTIVE:  done  = rise;
            PH_BLOCKED: ;
            default:    ;
        endcase
    end
endmodule

// File: rtl/fifo_store.sv
`timescale 1ns/1ps
module fifo_store #(
    parameter int AW = 12,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/strobe_fifo.sv
`timescale 1ns/1ps
module strobe_fifo #(
    parameter int AW = 12,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          full_n,
    output logic          empty_n,
    output logic          half_n
);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(1) << AW;
    localparam logic [CW-1:0] HALF_CNT = CW'(1) << (AW - 1);

    logic          wr_fall, wr_rise, rd_fall, rd_rise;
    logic          wr_start, wr_done, rd_start, rd_done;
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count, cnt_next;

    strobe_edge #(.SYNC_STAGES(2)) wr_edge_i (
        .clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .fall(wr_fall), .rise(wr_rise)
    );
    strobe_edge #(.SYNC_STAGES(2)) rd_edge_i (
        .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .fall(rd_fall), .rise(rd_rise)
    );

    strobe_phase_fsm wr_fsm_i (
        .clk(clk), .rst_n(rst_n), .fall(wr_fall), .rise(wr_rise),
        .block(~full_n), .start(wr_start), .done(wr_done)
    );
    strobe_phase_fsm rd_fsm_i (
        .clk(clk), .rst_n(rst_n), .fall(rd_fall), .rise(rd_rise),
        .block(~empty_n), .start(rd_start), .done(rd_done)
    );

    fifo_store #(.AW(AW), .DW(DW)) store_i (
        .clk(clk), .rst_n(rst_n),
        .we(wr_done), .waddr(wptr), .wdata(din),
        .re(rd_start), .raddr(rptr), .rdata(dout)
    );

    always_comb begin
        cnt_next = count;
        if (wr_done) cnt_next = cnt_next + 1'b1;
        if (rd_done) cnt_next = cnt_next - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            full_n  <= 1'b1;
            empty_n <= 1'b0;
            half_n  <= 1'b1;
        end else begin
            count <= cnt_next;
            if (wr_done) wptr <= wptr + 1'b1;
            if (rd_done) rptr <= rptr + 1'b1;
            if (wr_done || rd_done) begin
                full_n  <= (cnt_next != FULL_CNT);
                empty_n <= (cnt_next != '0);
            end
            // Half-full is set by a write's leading edge and cleared by a read's trailing edge.
            if (wr_start && count >= HALF_CNT)
                half_n <= 1'b0;
            else if (rd_done && cnt_next <= HALF_CNT)
                half_n <= 1'b1;
        end
    end
endmodule

// File: rtl/strobe_fifo_chk.sv
`timescale 1ns/1ps
module strobe_fifo_chk #(
    parameter int AW = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        full_n,
    input logic        empty_n,
    input logic        half_n,
    input logic        wr_start,
    input logic        rd_done,
    input logic [AW:0] count
);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(1) << AW;

    // R3: occupancy never passes the capacity
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R6: full is released only by a completed read
    p_full_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_n) |-> $past(rd_done));

    // R6, R7: full and empty never both asserted
    p_full_empty_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!full_n && !empty_n));

    // R7: empty asserted implies nothing stored
    p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> count == '0);

    // R8: half-full asserts only after an accepted write leading edge
    p_half_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(half_n) |-> $past(wr_start));

    // R9: half-full releases only after a completed read
    p_half_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_n) |-> $past(rd_done));
endmodule

bind strobe_fifo strobe_fifo_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .full_n(full_n), .empty_n(empty_n),
    .half_n(half_n), .wr_start(wr_start), .rd_done(rd_done), .count(count)
);

// File: tb/strobe_fifo_tb_top.sv
`timescale 1ns/1ps
module strobe_fifo_tb_top;
    localparam int AW    = 3;
    localparam int DW    = 9;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = DEPTH / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_n = 1'b1;
    logic          rd_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          full_n, empty_n, half_n;

    int total = 0;
    int bad   = 0;
    int q[$];
    logic exp_half_n = 1'b1;
    int   exp_dout   = 0;
    bit   rd_acc     = 1'b0;

    always #2 clk = ~clk;

    strobe_fifo #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .din(din),
        .dout(dout), .full_n(full_n), .empty_n(empty_n), .half_n(half_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        chk({req, " R6 full_n"},  int'(full_n),  int'(q.size() != DEPTH));
        chk({req, " R7 empty_n"}, int'(empty_n), int'(q.size() != 0));
        chk({req, " R9 half_n"},  int'(half_n),  int'(exp_half_n));
    endtask

    // Leading edge acts 3 clocks after the pin changes (R11); sample 4 negedges later.
    task automatic wr(input logic [DW-1:0] d);
        bit acc;
        din = d;
        @(negedge clk); wr_n = 1'b0;
        repeat (4) @(negedge clk);
        acc = (q.size() < DEPTH);
        if (acc && q.size() >= HALF) exp_half_n = 1'b0;
        chk("R8 half_n after write fall", int'(half_n), int'(exp_half_n));
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        if (acc) q.push_back(int'(d));
        chk_flags(acc ? "R2 write" : "R3 blocked write");
    endtask

    task automatic rd_begin();
        @(negedge clk); rd_n = 1'b0;
        repeat (4) @(negedge clk);
        rd_acc = (q.size() > 0);
        if (rd_acc) exp_dout = q[0];
        chk(rd_acc ? "R4 dout at read fall" : "R5 dout held on empty read",
            int'(dout), exp_dout);
    endtask

    task automatic rd_end();
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        if (rd_acc) begin
            void'(q.pop_front());
            if (q.size() <= HALF) exp_half_n = 1'b1;
        end
        chk_flags(rd_acc ? "R4 read" : "R5 blocked read");
    endtask

    task automatic rd();
        rd_begin();
        rd_end();
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: flags valid on the first clock after release
        chk("R1 empty_n", int'(empty_n), 0);
        chk("R1 full_n",  int'(full_n),  1);
        chk("R1 half_n",  int'(half_n),  1);
        chk("R1 dout",    int'(dout),    0);

        // R5: read of empty buffer leaves pointers alone; first write then reads back
        rd();
        wr(9'h0A5);
        rd();
        chk("R5 pointers kept after empty read", exp_dout, 9'h0A5);

        // Fill and drain sweeps with wrap-around (R10), overflow (R3) and underflow (R5) attempts
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < DEPTH + 1; i++)
                wr(DW'((r * 37 + i * 11 + 5) & 9'h1FF));
            for (int i = 0; i < DEPTH + 1; i++)
                rd();
        end

        // Mixed pattern: two writes then one read, across every occupancy
        for (int k = 0; k < 3 * DEPTH; k++) begin
            wr(DW'((k * 53 + 7) & 9'h1FF));
            if (k % 2 == 1) rd();
        end
        while (q.size() > 0) rd();

        // R10: write completes while a read strobe is held low
        for (int n = 1; n < DEPTH; n++) begin
            for (int i = 0; i < n; i++) wr(DW'(100 + n * 8 + i));
            rd_begin();
            wr(DW'(300 + n));
            rd_end();
            while (q.size() > 0) rd();
        end

        // R1: reset in the middle of a run discards contents
        for (int i = 0; i < 6; i++) wr(DW'(400 + i));
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        q.delete();
        exp_half_n = 1'b1;
        exp_dout = 0;
        @(negedge clk);
        chk_flags("R1 after mid-run reset");
        chk("R1 dout after reset", int'(dout), 0);
        wr(9'h1C3);
        rd();
        chk("R1 pointers restart", exp_dout, 9'h1C3);

        finish_run();
    end
endmodule